// File: doc/BRIEF.md
# Parallel-Input Signature Compactor with Pattern Generator Mode

This block is a small shift register with internal feedback that serves two purposes in a built-in self-test arrangement. In compaction mode it takes several response bits from a circuit under test on every enabled clock. It XORs each response bit into its own stage, together with the register's feedback, so that a whole run of responses folds into a single signature of `W` bits. At the end of the test, that signature is compared with the signature of a known-good circuit. In generator mode the same register ignores its data inputs and steps through a maximal-length pseudo-random sequence, which a test controller can apply as stimulus.

The feedback uses the internal-XOR arrangement. The top stage feeds back into stage 0, and it also feeds the XOR gate in front of every stage whose tap bit is set. The default taps give the characteristic polynomial 1 + x^2 + x^3, which has period 7 for three stages. `NUM_IN` may be smaller than `W`. In that case the stages at index `NUM_IN` and above have no data XOR, and the `din` port is only `NUM_IN` bits wide. The state of `gen_mode` at reset chooses the starting value: zero for compaction, or a nonzero seed for generation.

Top module: `misr_bilbo`

## Requirements
- R1: A cycle with `rst` high and `gen_mode` low leaves `sig` at all zeros after that clock edge.
- R2: A cycle with `rst` high and `gen_mode` high leaves `sig` equal to `SEED` (default 3'b001) after that clock edge.
- R3: When `rst` is low and `en` is low, `sig` keeps its value across the clock edge whatever `gen_mode` and `din` are.
- R4: In compaction mode (`gen_mode` = 0, `en` = 1), with default taps the next value is sig[0] = sig[2]^din[0], sig[1] = sig[0]^din[1], sig[2] = sig[1]^sig[2]^din[2]. In general, stage 0 takes the top stage, and stage k takes stage k-1, XORed with the top stage when TAPS[k] is 1.
- R5: In generator mode (`gen_mode` = 1, `en` = 1), `din` has no effect, and the register takes the R4 next value with all data bits at zero.
- R6: From the default seed, generator mode steps through 001, 010, 100, 101, 111, 011, 110 and returns to 001. It visits every nonzero state once per period of 7 and never reaches zero.
- R7: With `NUM_IN` = 2, stage 2 takes no data bit. Its next value is always sig[1]^sig[2], and stages 0 and 1 follow R4.
- R8: Starting from a compaction reset, the final signature of a 16-cycle input stream changes whenever exactly one input bit of that stream is inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset; its value depends on `gen_mode` |
| gen_mode | input | 1 | 1 = pattern generator, 0 = response compaction |
| en | input | 1 | Advance the register when 1, hold when 0 |
| din | input | NUM_IN | Parallel response bits, bit k goes to stage k |
| sig | output | W | Current register contents (signature or pattern) |

## Verification
Mode selection and data injection meet in the same cycle. The bench toggles `din` randomly on every generator step and checks each state against the fixed sequence, so any leak of data in generator mode breaks the sequence. Reset and mode also coincide: the bench asserts reset with each value of `gen_mode` and judges the loaded value as zero or the seed. The second instance with two inputs drives a data pattern that would flip stage 2 if its XOR were present. Its result is compared with a model in which that stage has no input.

// File: rtl/misr_bilbo.sv
module misr_bilbo #(
  parameter int W = 3,
  parameter int NUM_IN = 3,
  parameter logic [W-1:0] TAPS = 3'b100,
  parameter logic [W-1:0] SEED = 3'b001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_mode,
  input  logic              en,
  input  logic [NUM_IN-1:0] din,
  output logic [W-1:0]      sig
);

  logic [W-1:0] inj;
  logic [W-1:0] nxt;
  logic         fb;

  assign fb = sig[W-1];

  for (genvar k = 0; k < W; k++) begin : g_stage
    if (k < NUM_IN) begin : g_in
      assign inj[k] = din[k] & ~gen_mode;
    end else begin : g_noin
      assign inj[k] = 1'b0;
    end
    if (k == 0) begin : g_first
      assign nxt[k] = fb ^ inj[k];
    end else begin : g_rest
      assign nxt[k] = sig[k-1] ^ (TAPS[k] & fb) ^ inj[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     sig <= gen_mode ? SEED : '0;
    else if (en) sig <= nxt;
  end

endmodule

module misr_bilbo_chk #(
  parameter int W = 3,
  parameter int NUM_IN = 3,
  parameter logic [W-1:0] SEED = 3'b001
) (
  input logic              clk,
  input logic              rst,
  input logic              gen_mode,
  input logic              en,
  input logic [NUM_IN-1:0] din,
  input logic [W-1:0]      sig
);

  assert_clear_R1: assert property (@(posedge clk)
    rst && !gen_mode |=> sig == '0);

  assert_seed_R2: assert property (@(posedge clk)
    rst && gen_mode |=> sig == SEED);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sig));

  assert_zero_stays_R4: assert property (@(posedge clk) disable iff (rst)
    en && !gen_mode && din == '0 && sig == '0 |=> sig == '0);

  assert_nonzero_gen_R6: assert property (@(posedge clk) disable iff (rst)
    gen_mode && sig != '0 |=> sig != '0);

endmodule

bind misr_bilbo misr_bilbo_chk #(.W(W), .NUM_IN(NUM_IN), .SEED(SEED)) u_chk (
  .clk(clk), .rst(rst), .gen_mode(gen_mode), .en(en), .din(din), .sig(sig)
);

// File: tb/sim_misr_bilbo.sv
module sim_misr_bilbo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gen_mode = 1'b0;
  logic en = 1'b0;
  logic [2:0] din = '0;
  logic [1:0] din1 = '0;
  logic [2:0] sig, sig1;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  misr_bilbo #(.W(3), .NUM_IN(3)) u0 (
    .clk(clk), .rst(rst), .gen_mode(gen_mode), .en(en), .din(din), .sig(sig));
  misr_bilbo #(.W(3), .NUM_IN(2)) u1 (
    .clk(clk), .rst(rst), .gen_mode(gen_mode), .en(en), .din(din1), .sig(sig1));

  function automatic logic [2:0] model(input logic [2:0] s, input logic [2:0] d,
                                       input logic g, input int nin);
    logic [2:0] dd;
    dd = g ? 3'b000 : d;
    if (nin < 3) dd[2] = 1'b0;
    return {s[1] ^ s[2] ^ dd[2], s[0] ^ dd[1], s[2] ^ dd[0]};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1; gen_mode = m; en = 1'b0;
    tick();
    rst = 1'b0;
  endtask

  task automatic run_stream(input logic [47:0] s, output logic [2:0] f);
    do_reset(1'b0);
    en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      din = s[3*i +: 3];
      tick();
    end
    en = 1'b0;
    f = sig;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] exp0, exp1, prev, f0, f1;
    logic [47:0] st;
    logic [7:0] seen;
    @(negedge clk);

    do_reset(1'b0);
    check("R1", sig, 3'b000);
    check("R1", sig1, 3'b000);
    do_reset(1'b1);
    check("R2", sig, 3'b001);

    // R6 with R5: random din during generation
    begin
      logic [2:0] seq [7] = '{3'b010, 3'b100, 3'b101, 3'b111, 3'b011, 3'b110, 3'b001};
      seen = 8'b0000_0010;
      en = 1'b1;
      for (int i = 0; i < 7; i++) begin
        din = 3'($urandom); din1 = 2'($urandom);
        tick();
        check("R5_R6", sig, seq[i]);
        check("R5", sig1, seq[i]);
        if (i < 6) begin
          checks++;
          if (seen[sig]) begin
            errors++;
            $display("FAIL R6 actual=repeat %b expected=new state", sig);
          end
          seen[sig] = 1'b1;
        end
      end
      check("R6", seen[0] ? 3'b001 : 3'b000, 3'b000);
    end

    // R3: hold in both modes with changing din
    for (int m = 0; m < 2; m++) begin
      gen_mode = m[0]; en = 1'b1; din = 3'b101;
      tick();
      prev = sig; en = 1'b0;
      for (int i = 0; i < 4; i++) begin
        din = 3'($urandom); din1 = 2'($urandom);
        tick();
        check("R3", sig, prev);
      end
    end

    // R4 exhaustive single step from zero, and R7 on stage 2
    for (int d = 0; d < 8; d++) begin
      do_reset(1'b0);
      en = 1'b1; din = 3'(d); din1 = din[1:0];
      tick();
      check("R4", sig, 3'(d));
      check("R7", sig1, {1'b0, din1});
    end

    // R4, R7: random streams compared step by step
    for (int r = 0; r < 40; r++) begin
      do_reset(1'b0);
      exp0 = '0; exp1 = '0; en = 1'b1;
      for (int i = 0; i < 16; i++) begin
        din = 3'($urandom); din1 = 2'($urandom);
        exp0 = model(exp0, din, 1'b0, 3);
        exp1 = model(exp1, {1'b1, din1}, 1'b0, 2);
        tick();
        check("R4", sig, exp0);
        check("R7", sig1, exp1);
      end
    end

    // R8: every single-bit flip of a stream alters the signature
    for (int r = 0; r < 3; r++) begin
      st = {16'($urandom), 32'($urandom)};
      run_stream(st, f0);
      for (int b = 0; b < 48; b++) begin
        run_stream(st ^ (48'd1 << b), f1);
        checks++;
        if (f1 === f0) begin
          errors++;
          $display("FAIL R8 actual=%b expected=not %b (bit %0d)", f1, f0, b);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule